// File: doc/BRIEF.md
# Masked-Write MAC Configuration Registers

This block holds the static configuration that an Ethernet MAC glue layer needs: which PHY interface is in use, the line speed, which reference clock feeds the transmit path, and the tap settings for the RGMII clock delay lines. Two registers are visible on a simple write port (valid, address, data) and on a combinational read port. Each register stores 16 configuration bits.

Every 32-bit write carries its own bit mask. The upper 16 bits of the write data say which of the lower 16 bits may change. A bit whose mask is 1 takes the new data bit. A bit whose mask is 0 keeps its value. Software can therefore set one field, clear another and leave the rest untouched in a single bus write, with no read-modify-write sequence and no race against other writers of the same register.

The stored bits are decoded into plain control signals for the clock and delay logic around the MAC. Those neighbours sit outside this block.

Top module: `macglue_cfg_regs`

## Requirements
- R1: A synchronous active-high reset clears both registers to zero. After reset every read returns zero, the decoded 125 MHz RGMII clock select is 1, and every other decoded output is 0.
- R2: A write to a mapped offset sets stored bit n (0..15) to write-data bit n when write-data bit n+16 is 1. When write-data bit n+16 is 0, stored bit n keeps its previous value. The new value is visible from the clock edge that accepts the write.
- R3: A write to a mapped offset whose upper 16 data bits are all zero leaves that register unchanged.
- R4: A read of a mapped offset returns the stored 16 bits in rd_data[15:0] and zeros in rd_data[31:16].
- R5: The interface/speed register sits at offset 0x248 and the delay register at offset 0x250. A write to any other offset changes neither register. A read from any other offset returns zero.
- R6: Interface/speed register bits 8:6 select the PHY interface. Code 3'b001 asserts `intf_rgmii`, code 3'b100 asserts `intf_rmii`, and every other code asserts neither.
- R7: In the interface/speed register, the bits drive these outputs:
  - bit 9 drives `flow_ctrl_en`;
  - bit 10 drives `mii_100m` (1 = 100 Mb/s, 0 = 10 Mb/s);
  - bit 11 drives `rmii_clk_25m` (1 = 25 MHz, 0 = 2.5 MHz);
  - bit 14 drives `rmii_mode_en`.
- R8: Interface/speed register bits 13:12 pick the RGMII transmit clock, and exactly one of four outputs is asserted:
  - 2'b00 gives `rgmii_clk_125m`;
  - 2'b11 gives `rgmii_clk_25m`;
  - 2'b10 gives `rgmii_clk_2p5m`;
  - the undefined code 2'b01 gives `rgmii_clk_err`.
- R9: In the delay register, bits 6:0 drive `tx_dly`, bits 13:7 drive `rx_dly`, bit 14 drives `tx_dly_en` and bit 15 drives `rx_dly_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Mask in [31:16], data in [15:0] |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| intf_rgmii | output | 1 | RGMII interface selected |
| intf_rmii | output | 1 | RMII interface selected |
| flow_ctrl_en | output | 1 | Flow control enable |
| mii_100m | output | 1 | MII speed is 100 Mb/s |
| rmii_clk_25m | output | 1 | RMII clock is 25 MHz |
| rmii_mode_en | output | 1 | RMII mode enable |
| rgmii_clk_125m | output | 1 | RGMII transmit clock is 125 MHz |
| rgmii_clk_25m | output | 1 | RGMII transmit clock is 25 MHz |
| rgmii_clk_2p5m | output | 1 | RGMII transmit clock is 2.5 MHz |
| rgmii_clk_err | output | 1 | Undefined RGMII clock code stored |
| tx_dly | output | 7 | Transmit clock delay tap |
| rx_dly | output | 7 | Receive clock delay tap |
| tx_dly_en | output | 1 | Transmit clock delay enable |
| rx_dly_en | output | 1 | Receive clock delay enable |

## Verification
The assertions check these behaviours on every cycle:
- Unmasked bits keep their value across a write.
- Masked bits take the written data.
- A write with an empty mask, or to an unmapped offset, leaves both registers unchanged.
- The four RGMII clock flags stay one-hot.
- The two interface flags never assert together.
- An unmapped read returns zero.

Only the bench's scenarios can show that each field sits at the right bit position and that each code decodes to the right output. To do this, the bench sweeps every combination of bits 15:6 of the interface register and a strided range of delay-register values. It also covers partial-mask writes, reset in the middle of a run, and unmapped offsets.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int CFG_W    = 16;
    localparam int DLY_W    = 7;
    localparam int NUM_REGS = 2;

    typedef enum logic [1:0] {
        CK_125M = 2'b00,
        CK_BAD  = 2'b01,
        CK_2P5M = 2'b10,
        CK_25M  = 2'b11
    } rgmii_ck_e;

    // interface/speed register layout, MSB first
    typedef struct packed {
        logic       spare15;
        logic       rmii_mode;
        rgmii_ck_e  ck_sel;
        logic       rmii_ck25;
        logic       spd100;
        logic       flow;
        logic [2:0] intf;
        logic [5:0] spare_lo;
    } ifc_cfg_t;

    // delay register layout, MSB first
    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [DLY_W-1:0] rx_tap;
        logic [DLY_W-1:0] tx_tap;
    } dly_cfg_t;

    localparam logic [2:0] INTF_RGMII = 3'b001;
    localparam logic [2:0] INTF_RMII  = 3'b100;

    function automatic logic [CFG_W-1:0] masked_merge(
        input logic [CFG_W-1:0] old_v,
        input logic [CFG_W-1:0] new_v,
        input logic [CFG_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/mcr_masked_reg.sv
module mcr_masked_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= (q & ~wr_mask) | (wr_val & wr_mask);
    end

    // R1: reset clears the register
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> q == '0);

    // R2: bits outside the mask never move during a write
    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((q ^ $past(q)) & ~$past(wr_mask)) == '0);

    // R2: bits inside the mask take the written data
    assert_masked_take_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask)));

    // R3: an empty mask leaves the register unchanged
    assert_empty_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mask == '0) |=> $stable(q));

endmodule

// File: rtl/mcr_ifc_decode.sv
module mcr_ifc_decode
    import mcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ifc_cfg_t cfg,
    output logic     intf_rgmii,
    output logic     intf_rmii,
    output logic     flow_ctrl_en,
    output logic     mii_100m,
    output logic     rmii_clk_25m,
    output logic     rmii_mode_en,
    output logic     rgmii_clk_125m,
    output logic     rgmii_clk_25m,
    output logic     rgmii_clk_2p5m,
    output logic     rgmii_clk_err
);

    always_comb begin
        intf_rgmii   = (cfg.intf == INTF_RGMII);
        intf_rmii    = (cfg.intf == INTF_RMII);
        flow_ctrl_en = cfg.flow;
        mii_100m     = cfg.spd100;
        rmii_clk_25m = cfg.rmii_ck25;
        rmii_mode_en = cfg.rmii_mode;
    end

    always_comb begin
        rgmii_clk_125m = 1'b0;
        rgmii_clk_25m  = 1'b0;
        rgmii_clk_2p5m = 1'b0;
        rgmii_clk_err  = 1'b0;
        unique case (cfg.ck_sel)
            CK_125M: rgmii_clk_125m = 1'b1;
            CK_25M:  rgmii_clk_25m  = 1'b1;
            CK_2P5M: rgmii_clk_2p5m = 1'b1;
            default: rgmii_clk_err  = 1'b1;
        endcase
    end

    // R8: exactly one clock-select flag at all times
    assert_ck_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({rgmii_clk_125m, rgmii_clk_25m, rgmii_clk_2p5m, rgmii_clk_err}) == 1);

    // R6: the two interface flags are exclusive
    assert_intf_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(intf_rgmii && intf_rmii));

endmodule

// File: rtl/mcr_dly_decode.sv
module mcr_dly_decode
    import mcr_pkg::*;
(
    input  dly_cfg_t         cfg,
    output logic [DLY_W-1:0] tx_dly,
    output logic [DLY_W-1:0] rx_dly,
    output logic             tx_dly_en,
    output logic             rx_dly_en
);

    always_comb begin
        tx_dly    = cfg.tx_tap;
        rx_dly    = cfg.rx_tap;
        tx_dly_en = cfg.tx_en;
        rx_dly_en = cfg.rx_en;
    end

endmodule

// File: rtl/macglue_cfg_regs.sv
module macglue_cfg_regs
    import mcr_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] IFC_OFF = 12'h248,
    parameter logic [ADDR_W-1:0] DLY_OFF = 12'h250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              intf_rgmii,
    output logic              intf_rmii,
    output logic              flow_ctrl_en,
    output logic              mii_100m,
    output logic              rmii_clk_25m,
    output logic              rmii_mode_en,
    output logic              rgmii_clk_125m,
    output logic              rgmii_clk_25m,
    output logic              rgmii_clk_2p5m,
    output logic              rgmii_clk_err,
    output logic [DLY_W-1:0]  tx_dly,
    output logic [DLY_W-1:0]  rx_dly,
    output logic              tx_dly_en,
    output logic              rx_dly_en
);

    localparam int BUS_W = 2 * CFG_W;
    localparam logic [ADDR_W-1:0] OFFS [NUM_REGS] = '{IFC_OFF, DLY_OFF};

    logic [CFG_W-1:0] cfg_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_valid && (wr_addr == OFFS[g]);

        mcr_masked_reg #(.W(CFG_W)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (hit),
            .wr_val  (wr_data[CFG_W-1:0]),
            .wr_mask (wr_data[BUS_W-1:CFG_W]),
            .q       (cfg_q[g])
        );

        // R5: a write elsewhere leaves this register alone
        assert_other_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_valid && wr_addr != OFFS[g]) |=> $stable(cfg_q[g]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == OFFS[i])
                rd_data = {{(BUS_W-CFG_W){1'b0}}, cfg_q[i]};
    end

    // R5: unmapped read returns zero
    assert_unmapped_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != IFC_OFF && rd_addr != DLY_OFF) |-> rd_data == '0);

    mcr_ifc_decode u_ifc (
        .clk            (clk),
        .rst            (rst),
        .cfg            (ifc_cfg_t'(cfg_q[0])),
        .intf_rgmii     (intf_rgmii),
        .intf_rmii      (intf_rmii),
        .flow_ctrl_en   (flow_ctrl_en),
        .mii_100m       (mii_100m),
        .rmii_clk_25m   (rmii_clk_25m),
        .rmii_mode_en   (rmii_mode_en),
        .rgmii_clk_125m (rgmii_clk_125m),
        .rgmii_clk_25m  (rgmii_clk_25m),
        .rgmii_clk_2p5m (rgmii_clk_2p5m),
        .rgmii_clk_err  (rgmii_clk_err)
    );

    mcr_dly_decode u_dly (
        .cfg       (dly_cfg_t'(cfg_q[1])),
        .tx_dly    (tx_dly),
        .rx_dly    (rx_dly),
        .tx_dly_en (tx_dly_en),
        .rx_dly_en (rx_dly_en)
    );

endmodule

// File: tb/sim_macglue_cfg_regs.sv
module sim_macglue_cfg_regs;

    localparam logic [11:0] A_IFC = 12'h248;
    localparam logic [11:0] A_DLY = 12'h250;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic intf_rgmii, intf_rmii, flow_ctrl_en, mii_100m, rmii_clk_25m, rmii_mode_en;
    logic rgmii_clk_125m, rgmii_clk_25m, rgmii_clk_2p5m, rgmii_clk_err;
    logic [6:0] tx_dly, rx_dly;
    logic tx_dly_en, rx_dly_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_ifc = '0;
    logic [15:0] m_dly = '0;

    always #5 clk = ~clk;

    macglue_cfg_regs u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        if (a == A_IFC) m_ifc = (m_ifc & ~d[31:16]) | (d[15:0] & d[31:16]);
        if (a == A_DLY) m_dly = (m_dly & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, {16'h0, exp});
    endtask

    // expected decode from the requirements
    task automatic dec_chk();
        logic [2:0] it;
        logic [1:0] ck;
        it = m_ifc[8:6];
        ck = m_ifc[13:12];
        chk("R6", {30'h0, intf_rgmii, intf_rmii}, {30'h0, it == 3'd1, it == 3'd4});
        chk("R7", {28'h0, flow_ctrl_en, mii_100m, rmii_clk_25m, rmii_mode_en},
            {28'h0, m_ifc[9], m_ifc[10], m_ifc[11], m_ifc[14]});
        chk("R8", {28'h0, rgmii_clk_125m, rgmii_clk_25m, rgmii_clk_2p5m, rgmii_clk_err},
            {28'h0, ck == 2'd0, ck == 2'd3, ck == 2'd2, ck == 2'd1});
        chk("R9", {16'h0, rx_dly_en, tx_dly_en, rx_dly, tx_dly},
            {16'h0, m_dly[15], m_dly[14], m_dly[13:7], m_dly[6:0]});
    endtask

    task automatic full_chk();
        rd_chk("R4", A_IFC, m_ifc);
        rd_chk("R4", A_DLY, m_dly);
        dec_chk();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd_chk("R1", A_IFC, 16'h0);
        rd_chk("R1", A_DLY, 16'h0);
        dec_chk();

        // R6 R7 R8: sweep bits 15:6 of the interface register, full mask
        for (int i = 0; i < 1024; i++) begin
            wr(A_IFC, {16'hFFFF, i[9:0], i[5:0]});
            full_chk();
        end

        // R9: strided sweep of the delay register
        for (int v = 0; v < 65536; v += 97) begin
            wr(A_DLY, {16'hFFFF, v[15:0]});
            full_chk();
        end

        // R2: partial masks with pseudo-random data
        lf = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            wr(k[0] ? A_DLY : A_IFC, lf);
            rd_chk("R2", A_IFC, m_ifc);
            rd_chk("R2", A_DLY, m_dly);
            dec_chk();
        end

        // R2: per-field masked writes to the delay register
        wr(A_DLY, 32'hFFFF_0000);
        wr(A_DLY, {9'h0, 7'h7F, 9'h0, 7'h55});
        rd_chk("R2", A_DLY, 16'h0055);
        wr(A_DLY, {2'b00, 7'h7F, 7'h00, 2'b00, 7'h2A, 7'h11});
        rd_chk("R2", A_DLY, {2'b00, 7'h2A, 7'h55});
        dec_chk();

        // R3: empty mask leaves contents
        wr(A_IFC, 32'hFFFF_5A5A);
        wr(A_IFC, 32'h0000_A5A5);
        rd_chk("R3", A_IFC, 16'h5A5A);
        wr(A_DLY, 32'h0000_FFFF);
        rd_chk("R3", A_DLY, m_dly);
        dec_chk();

        // R5: unmapped offsets
        foreach (lf[j]) begin end
        wr(12'h24C, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_0000);
        wr(12'h254, 32'hFFFF_1234);
        wr(12'hA48, 32'hFFFF_0000);
        rd_chk("R5", A_IFC, 16'h5A5A);
        rd_chk("R5", A_DLY, m_dly);
        rd_chk("R5", 12'h24C, 16'h0);
        rd_chk("R5", 12'h000, 16'h0);
        rd_chk("R5", 12'hFFF, 16'h0);

        // R1: reset in mid-run
        wr(A_DLY, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ifc = '0;
        m_dly = '0;
        rd_chk("R1", A_IFC, 16'h0);
        rd_chk("R1", A_DLY, 16'h0);
        dec_chk();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule